// File: doc/BRIEF.md
# Boost PWM Gate Sequencer

This block generates the switching gate for a boost power-factor stage running in continuous conduction. It runs from a fixed system clock and divides time into switching periods of a programmable number of clocks. Each period opens with a forced off interval. During that interval the ramp-enable output stays low, so an external ramp capacitor is held discharged. Once the interval ends, the ramp is released. The gate turns on when an external comparator reports that the ramp has crossed the averaged inductor-current level. The gate then stays on until the period ends. The result is an off time that grows with the average current.

Two protection inputs override the normal sequence. A peak-current-limit comparator output passes through a clock-count deglitch filter. A pulse that survives the filter latches the gate off for the rest of the period and produces a one-clock trip pulse. An open-loop input, raised when the sensed output voltage is far below nominal, keeps the gate off for as long as it is asserted. The start of every period clears both the limit latch and the on latch, and this clearing takes priority over all other inputs. The period length, the off-interval length and the deglitch length are count inputs. They are captured at reset and at each period boundary.

Top module: `boost_gate_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block loads the count inputs and clears its state. After that edge, `gate_o` and `ilim_trip_o` are 0, and the position in the period is 0.
- R2: A period of P clocks has positions 0 to P-1. During positions below M, the captured off length, `ramp_en_o` is 0 and `gate_o` is 0. At positions M and above, `ramp_en_o` is 1.
- R3: If `ramp_cross` is 1 in a clock at which `ramp_en_o` is 1 and the position is not P-1, and no limit or open-loop condition blocks it, then `gate_o` is 1 from the next clock. It stays 1 through position P-1 even if `ramp_cross` falls.
- R4: With `ramp_cross` held at 1 and no protection active, `gate_o` is high for exactly P-M-1 clocks of each period.
- R5: The limit filter fires only when `ilim_raw` has been 1 for D consecutive clocks, counting the present one. D is the captured deglitch length. Any clock with `ilim_raw` at 0 restarts the count, so shorter pulses have no effect on `gate_o` or `ilim_trip_o`.
- R6: When the filter fires at a position between M and P-2, `gate_o` is 0 from the next clock until the period ends. At the same clock, `ilim_trip_o` is 1 for exactly one clock, and only if the limit latch was not already set in that period.
- R7: In any clock after one in which `open_loop` is 1, `gate_o` is 0.
- R8: Count inputs are captured only at reset and in the last clock of a period, for use in the next period. A period length below 2 is treated as 2, and a deglitch length of 0 is treated as 1.
- R9: Position 0 of each period starts with both latches clear. A limit or gate-on state from the previous period never carries over, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_len | input | CW | Switching period in clocks |
| min_off_len | input | CW | Forced off interval in clocks at the start of a period |
| glitch_len | input | CW | Clocks the limit input must stay high before acting |
| ramp_cross | input | 1 | Comparator output: ramp has crossed the averaged-current level |
| ilim_raw | input | 1 | Raw peak-current-limit comparator output |
| open_loop | input | 1 | Output-voltage-too-low indication; blocks the gate |
| gate_o | output | 1 | Registered gate drive command |
| ramp_en_o | output | 1 | High releases the external ramp; low keeps it discharged |
| ilim_trip_o | output | 1 | One-clock pulse when the peak limit ends a period |

## Verification
The hardest case to reach is a limit pulse exactly D clocks long that lands inside the ramp phase. A pulse one clock shorter must not trip, and neither must a long pulse that straddles a period boundary. The stimulus drives the limit input in random bursts of one to eight clocks against deglitch lengths of one to six, and it changes the count inputs in the middle of a period. A directed pattern then feeds repeated pulses exactly one clock short of the threshold. Every clock is compared against a reference model in the bench that captures the counts only at the period boundary.

// File: rtl/boost_gate_seq.sv
module boost_gate_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_len,
  input  logic [CW-1:0] min_off_len,
  input  logic [CW-1:0] glitch_len,
  input  logic          ramp_cross,
  input  logic          ilim_raw,
  input  logic          open_loop,
  output logic          gate_o,
  output logic          ramp_en_o,
  output logic          ilim_trip_o
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] TWO  = CW'(2);
  localparam logic [CW-1:0] FULL = '1;

  logic [CW-1:0] pos, per_q, moff_q, dgl_q, dg_cnt;
  logic          on_lat, lim_lat, trip_q;

  wire wrap    = (pos == per_q - ONE);
  wire in_moff = (pos < moff_q);
  wire blank   = wrap | in_moff;
  wire fire    = ilim_raw & (dg_cnt >= dgl_q - ONE);
  wire lim_set = fire & ~blank;
  wire on_kill = blank | open_loop | fire | lim_lat;

  wire [CW-1:0] per_in = (period_len < TWO) ? TWO : period_len;
  wire [CW-1:0] dgl_in = (glitch_len == '0) ? ONE : glitch_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      per_q   <= per_in;
      moff_q  <= min_off_len;
      dgl_q   <= dgl_in;
      dg_cnt  <= '0;
      on_lat  <= 1'b0;
      lim_lat <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      pos <= wrap ? '0 : pos + ONE;
      if (wrap) begin
        per_q  <= per_in;
        moff_q <= min_off_len;
        dgl_q  <= dgl_in;
      end
      if (!ilim_raw)             dg_cnt <= '0;
      else if (dg_cnt != FULL)   dg_cnt <= dg_cnt + ONE;
      trip_q  <= lim_set & ~lim_lat;
      lim_lat <= blank ? 1'b0 : (lim_lat | fire);
      on_lat  <= on_kill ? 1'b0 : (on_lat | ramp_cross);
    end
  end

  assign gate_o      = on_lat;
  assign ramp_en_o   = ~in_moff;
  assign ilim_trip_o = trip_q;
endmodule

module boost_gate_seq_chk (
  input logic clk,
  input logic rst,
  input logic ramp_cross,
  input logic open_loop,
  input logic gate_o,
  input logic ramp_en_o,
  input logic ilim_trip_o
);
  // R2
  gate_off_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !ramp_en_o |-> !gate_o);
  // R7
  open_loop_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    open_loop |=> !gate_o);
  // R6
  trip_gate_low_chk: assert property (@(posedge clk) disable iff (rst)
    ilim_trip_o |-> !gate_o);
  // R6
  trip_single_chk: assert property (@(posedge clk) disable iff (rst)
    ilim_trip_o |=> !ilim_trip_o);
  // R3
  rise_needs_cross_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> ($past(ramp_cross) && $past(ramp_en_o)));
endmodule

bind boost_gate_seq boost_gate_seq_chk u_chk (
  .clk(clk), .rst(rst), .ramp_cross(ramp_cross), .open_loop(open_loop),
  .gate_o(gate_o), .ramp_en_o(ramp_en_o), .ilim_trip_o(ilim_trip_o)
);

// File: tb/boost_gate_seq_bench.sv
module boost_gate_seq_bench;
  localparam int CLK_NS = 10;
  localparam int CW = 16;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst;
  logic [CW-1:0] period_len, min_off_len, glitch_len;
  logic ramp_cross, ilim_raw, open_loop;
  logic gate_o, ramp_en_o, ilim_trip_o;

  boost_gate_seq #(.CW(CW)) u_boost_gate_seq (
    .clk(clk), .rst(rst), .period_len(period_len), .min_off_len(min_off_len),
    .glitch_len(glitch_len), .ramp_cross(ramp_cross), .ilim_raw(ilim_raw),
    .open_loop(open_loop), .gate_o(gate_o), .ramp_en_o(ramp_en_o),
    .ilim_trip_o(ilim_trip_o)
  );

  int total = 0, bad = 0;
  int m_pos, m_per, m_moff, m_dgl, m_run;
  bit m_on, m_lim, m_trip;

  function automatic int per_of(int v); return (v < 2) ? 2 : v; endfunction
  function automatic int dgl_of(int v); return (v == 0) ? 1 : v; endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      if (bad < 25) $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit last, early, trig;
    if (rst) begin
      m_pos = 0; m_per = per_of(int'(period_len)); m_moff = int'(min_off_len);
      m_dgl = dgl_of(int'(glitch_len)); m_run = 0; m_on = 0; m_lim = 0; m_trip = 0;
      return;
    end
    last  = (m_pos == m_per - 1);
    early = (m_pos < m_moff);
    trig  = ilim_raw && (m_run + 1 >= m_dgl);
    m_trip = trig && !last && !early && !m_lim;
    if (last || early || open_loop || trig || m_lim) m_on = 0;
    else if (ramp_cross) m_on = 1;
    m_lim = (last || early) ? 0 : (m_lim || trig);
    m_run = ilim_raw ? m_run + 1 : 0;
    if (last) begin
      m_pos = 0; m_per = per_of(int'(period_len)); m_moff = int'(min_off_len);
      m_dgl = dgl_of(int'(glitch_len));
    end else m_pos++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 R3 R6 R7 R9 gate", gate_o, m_on);
    chk("R2 ramp_en", ramp_en_o, (m_pos >= m_moff));
    chk("R5 R6 trip", ilim_trip_o, m_trip);
  endtask

  int burst;
  int cnt;
  bit prev_ramp;

  initial begin
    rst = 1; period_len = 40; min_off_len = 5; glitch_len = 3;
    ramp_cross = 0; ilim_raw = 0; open_loop = 0;
    @(negedge clk);
    step();
    // R1 reset state
    chk("R1 gate after reset", gate_o, 0);
    chk("R1 trip after reset", ilim_trip_o, 0);
    chk("R1 ramp held after reset", ramp_en_o, 0);
    rst = 0;

    void'($urandom(32'd7771));
    burst = 0;
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 299) == 0) begin
        period_len  = CW'($urandom_range(0, 80));
        min_off_len = CW'($urandom_range(0, 10));
        glitch_len  = CW'($urandom_range(0, 6));
      end
      ramp_cross = ($urandom_range(0, 3) == 0);
      if (burst > 0) begin ilim_raw = 1; burst--; end
      else begin
        ilim_raw = 0;
        if ($urandom_range(0, 19) == 0) burst = $urandom_range(1, 8);
      end
      open_loop = ($urandom_range(0, 99) == 0);
      if ($urandom_range(0, 4999) == 0) rst = 1; else rst = 0;
      step();
    end
    rst = 0;

    // R4 R8: full duty with fixed counts
    period_len = 40; min_off_len = 5; glitch_len = 4;
    ramp_cross = 1; ilim_raw = 0; open_loop = 0;
    for (int i = 0; i < 200; i++) step();
    prev_ramp = ramp_en_o;
    for (int i = 0; i < 200; i++) begin
      step();
      if (prev_ramp && !ramp_en_o) break;
      prev_ramp = ramp_en_o;
    end
    cnt = gate_o;
    for (int i = 0; i < 39; i++) begin step(); cnt += gate_o; end
    chk("R4 on clocks per period", cnt, 34);

    // R5: pulses one clock short of the deglitch length
    cnt = 0;
    for (int i = 0; i < 160; i++) begin
      ilim_raw = ((i % 4) != 3);
      step();
      cnt += ilim_trip_o;
    end
    chk("R5 short pulses ignored", cnt, 0);
    ilim_raw = 0;
    for (int i = 0; i < 45; i++) step();

    // R6: held limit trips once per period
    ilim_raw = 1; cnt = 0;
    for (int i = 0; i < 80; i++) begin step(); cnt += ilim_trip_o; end
    chk("R6 one trip per period", cnt, 2);
    ilim_raw = 0;

    // R7: open loop blocks gate
    open_loop = 1; step(); cnt = 0;
    for (int i = 0; i < 100; i++) begin step(); cnt += gate_o; end
    chk("R7 gate held off", cnt, 0);
    open_loop = 0;

    // R8: short period clamp
    period_len = 1; min_off_len = 0;
    for (int i = 0; i < 60; i++) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule